// File: doc/BRIEF.md
# Due-Time Cell Resequencer

This block puts cells back in order at one output of a memoryless switch fabric whose input side may retry a head-of-line cell after younger cells from the same input have already crossed. It does not use sequence numbers. Every cell that enters the fabric is stamped with an absolute release slot. That slot is the value of a free-running slot counter plus a fixed worst-case disorder bound. On the output side the stamped cells wait in a small holding store. A cell becomes eligible to leave only when the slot counter equals its stamp. Because of this, every cell spends at least the bound in the store, even when there is no contention. In exchange, the output order matches the send order for any cell that crosses within the bound.

The bound defaults to the product of two terms computed from the fabric geometry. The first is the number of slots in one arbitration cycle, the ceiling of (ports + expanded group width − 1) / 424. The second is the worst-case number of tries, the ceiling of ports / expanded group width. With 1024 ports, groups of 16 and an expansion ratio of 5/4, this gives 3 × 52 = 156 slots. The slot counter and the stamps are k bits wide, where k is the smallest width with 2^k > 2·bound, and they wrap. One slot lasts `SLOT_CYC` clock cycles, so several cells that share a release slot can leave one per cycle within that slot.

Back-pressure rules are as follows:
- On the stamping path, `src_ready` equals `fab_ready`, and a cell moves when valid and ready are both high.
- The arrival port from the fabric has no ready signal, because the fabric cannot hold a cell. An arrival that finds the store full, with no release in that cycle, is dropped and sets a sticky overflow flag.
- On the release port, `out_valid` may stay high across slots while `out_ready` is low. An eligible cell is never lost to back-pressure.
- `out_data` may change while `out_valid` is high and `out_ready` is low, because an older cell can become eligible and take the head position.

Top module: `dt_reseq`

## Requirements
- R1: `fab_due` equals (`slot_now` + bound) modulo 2^k. `fab_valid` follows `src_valid`, `fab_data` follows `src_data`, and `src_ready` follows `fab_ready`, all in the same cycle.
- R2: `slot_now` is 0 after reset, advances by exactly one after every `SLOT_CYC` clock cycles, and wraps from 2^k − 1 to 0.
- R3: A held cell is never offered on the release port before the slot whose counter value equals its stamp. It is offered in the first cycle of that slot in which it is the oldest eligible cell.
- R4: A cell that arrives stamped with the current slot value is offered in the cycle after its arrival, even if the slot advances on that edge.
- R5: Eligible cells leave one per accepted handshake, oldest arrival first. This holds among cells that share one stamp, and it also holds between a cell whose slot has passed and younger cells.
- R6: While `out_ready` is low, an eligible cell stays in the store and is still offered in later slots.
- R7: An arrival that finds all `DEPTH` entries occupied, with no release in the same cycle, is discarded. It sets `overflow` to 1, which stays at 1 until reset, and the held cells are unchanged.
- R8: Reset empties the store, clears `overflow`, drives `out_valid` to 0 and sets `slot_now` to 0.
- R9: The default bound is ceil((N + LM − 1)/424) · ceil(N/LM). It gives 156 for N = 1024, M = 16, L = 5/4, and 8200 for N = 8192 with the same M and L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 1 | Input-side cell offered for stamping |
| src_ready | output | 1 | Fabric can take the stamped cell |
| src_data | input | DATA_W | Input-side cell payload |
| fab_valid | output | 1 | Stamped cell towards the fabric |
| fab_ready | input | 1 | Fabric accepts the stamped cell |
| fab_data | output | DATA_W | Stamped cell payload |
| fab_due | output | SLOT_W | Release slot stamped on the cell |
| rcv_valid | input | 1 | Cell arriving from the fabric |
| rcv_data | input | DATA_W | Arriving cell payload |
| rcv_due | input | SLOT_W | Arriving cell's release slot |
| out_valid | output | 1 | A held cell is eligible for release |
| out_ready | input | 1 | Output stage takes the offered cell |
| out_data | output | DATA_W | Offered cell payload |
| slot_now | output | SLOT_W | Current wrapped slot counter |
| overflow | output | 1 | Sticky: an arrival was dropped |

## Verification
Assertions check on every cycle that the slot counter steps only on a slot boundary and holds otherwise. They also check that the occupancy never exceeds `DEPTH`, that a release shrinks it by one when nothing arrives, that a full store with no release stays full when an arrival is dropped, that the overflow flag never falls, and that nothing is offered from an empty store. Other behaviours need the bench's scenarios: that a cell appears exactly in its stamped slot and not before, the release order among cells with equal and with lapsed stamps, survival under back-pressure, which cell is dropped when the store is full, and the value of the stamp.

// File: rtl/dt_reseq_pkg.sv
package dt_reseq_pkg;

  // Bits carried by one cell slot on a fabric line.
  localparam int CELL_BITS = 424;

  // Worst-case disorder bound in slots:
  // slots per arbitration cycle times the maximum number of tries.
  // The expansion ratio is given as exp_num/exp_den to stay in integers.
  function automatic int dt_bound(input int ports, input int group,
                                  input int exp_num, input int exp_den);
    int lm_x;
    int per_arb;
    int tries;
    lm_x    = group * exp_num;
    per_arb = (ports * exp_den + lm_x - exp_den + CELL_BITS * exp_den - 1)
              / (CELL_BITS * exp_den);
    tries   = (ports * exp_den + lm_x - 1) / lm_x;
    return per_arb * tries;
  endfunction

  // Smallest stamp width whose modulus exceeds twice the bound.
  function automatic int slot_bits(input int bound);
    return $clog2(2 * bound + 1);
  endfunction

endpackage

// File: rtl/dt_slot_timer.sv
module dt_slot_timer #(
  parameter int SLOT_CYC = 4,
  parameter int SLOT_W   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] slot
);

  logic [SLOT_W-1:0] slot_q;

  generate
    if (SLOT_CYC > 1) begin : g_divided
      localparam int CYC_W = $clog2(SLOT_CYC);
      localparam logic [CYC_W-1:0] LAST = CYC_W'(SLOT_CYC - 1);
      logic [CYC_W-1:0] cyc_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cyc_q  <= '0;
          slot_q <= '0;
        end else if (cyc_q == LAST) begin
          cyc_q  <= '0;
          slot_q <= slot_q + SLOT_W'(1);
        end else begin
          cyc_q  <= cyc_q + CYC_W'(1);
        end
      end

      // R2: the counter steps once at the end of each slot
      p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == LAST) |=> (slot_q == $past(slot_q) + SLOT_W'(1)));
      // R2: and holds inside the slot
      p_slot_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q != LAST) |=> $stable(slot_q));
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_q + SLOT_W'(1);
      end
    end
  endgenerate

  assign slot = slot_q;

endmodule

// File: rtl/dt_stamper.sv
module dt_stamper #(
  parameter int DATA_W  = 16,
  parameter int SLOT_W  = 9,
  parameter int T_BOUND = 156
) (
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [DATA_W-1:0] src_data,
  input  logic [SLOT_W-1:0] slot,
  output logic              fab_valid,
  input  logic              fab_ready,
  output logic [DATA_W-1:0] fab_data,
  output logic [SLOT_W-1:0] fab_due
);

  localparam logic [SLOT_W-1:0] T_MOD = SLOT_W'(T_BOUND);

  assign fab_valid = src_valid;
  assign src_ready = fab_ready;
  assign fab_data  = src_data;
  assign fab_due   = slot + T_MOD;   // wraps modulo 2^SLOT_W

endmodule

// File: rtl/dt_pick.sv
module dt_pick #(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  // Lowest index wins: entries are kept in arrival order.
  always_comb begin
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign found = |req;

endmodule

// File: rtl/dt_hold_buffer.sv
module dt_hold_buffer #(
  parameter int DATA_W = 16,
  parameter int SLOT_W = 9,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] slot,
  input  logic              rcv_valid,
  input  logic [DATA_W-1:0] rcv_data,
  input  logic [SLOT_W-1:0] rcv_due,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              overflow
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  // Compacting store: entry 0 is the oldest arrival.
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [SLOT_W-1:0] due_q  [DEPTH];
  logic [DEPTH-1:0]  ripe_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ovf_q;

  logic [DATA_W-1:0] data_n [DEPTH];
  logic [SLOT_W-1:0] due_n  [DEPTH];
  logic [DEPTH-1:0]  ripe_n;
  logic [CNT_W-1:0]  cnt_after;
  logic [CNT_W-1:0]  cnt_n;

  logic [DEPTH-1:0]  elig;
  logic              any_elig;
  logic [IDX_W-1:0]  sel;
  logic              pop;
  logic              room;
  logic              push;
  logic              drop;

  // An entry is eligible once its stamp has matched the slot counter.
  // The ripe bit remembers a match so back-pressure cannot lose it.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      elig[i] = (CNT_W'(i) < cnt_q) && (ripe_q[i] || (due_q[i] == slot));
    end
  end

  dt_pick #(.DEPTH(DEPTH)) u_pick (
    .req   (elig),
    .found (any_elig),
    .idx   (sel)
  );

  assign out_valid = any_elig;
  assign out_data  = data_q[sel];
  assign pop       = any_elig && out_ready;
  assign room      = (cnt_q != FULL) || pop;
  assign push      = rcv_valid && room;
  assign drop      = rcv_valid && !room;
  assign cnt_after = cnt_q - CNT_W'(pop);
  assign cnt_n     = cnt_after + CNT_W'(push);

  // Remove the released entry by shifting the younger ones down,
  // then append the arrival behind the survivors.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      int j;
      j = i;
      if (pop && (i >= int'(sel))) j = i + 1;
      if (j < DEPTH) begin
        data_n[i] = data_q[j];
        due_n[i]  = due_q[j];
        ripe_n[i] = elig[j];
      end else begin
        data_n[i] = '0;
        due_n[i]  = '0;
        ripe_n[i] = 1'b0;
      end
      if (push && (CNT_W'(i) == cnt_after)) begin
        data_n[i] = rcv_data;
        due_n[i]  = rcv_due;
        ripe_n[i] = (rcv_due == slot);
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      data_q[i] <= data_n[i];
      due_q[i]  <= due_n[i];
    end
    if (!rst_n) begin
      cnt_q  <= '0;
      ripe_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      ripe_q <= ripe_n;
      if (drop) ovf_q <= 1'b1;
    end
  end

  assign overflow = ovf_q;

  // R7: occupancy stays within the store
  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
  // R7: a dropped arrival leaves the full store full and flags overflow
  p_drop_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rcv_valid && (cnt_q == FULL) && !(out_valid && out_ready))
    |=> (cnt_q == FULL) && overflow);
  // R7: the overflow flag is sticky
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R3: nothing is offered from an empty store
  p_offer_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (cnt_q != '0));
  // R5: one accepted handshake removes exactly one cell
  p_pop_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !rcv_valid) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/dt_reseq.sv
module dt_reseq
  import dt_reseq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int DEPTH    = 8,
  parameter int SLOT_CYC = 4,
  parameter int SW_PORTS = 1024,
  parameter int GRP_SIZE = 16,
  parameter int EXP_NUM  = 5,
  parameter int EXP_DEN  = 4,
  parameter int T_BOUND  = dt_bound(SW_PORTS, GRP_SIZE, EXP_NUM, EXP_DEN),
  parameter int SLOT_W   = slot_bits(T_BOUND)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [DATA_W-1:0] src_data,
  output logic              fab_valid,
  input  logic              fab_ready,
  output logic [DATA_W-1:0] fab_data,
  output logic [SLOT_W-1:0] fab_due,
  input  logic              rcv_valid,
  input  logic [DATA_W-1:0] rcv_data,
  input  logic [SLOT_W-1:0] rcv_due,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [SLOT_W-1:0] slot_now,
  output logic              overflow
);

  logic [SLOT_W-1:0] slot;

  dt_slot_timer #(.SLOT_CYC(SLOT_CYC), .SLOT_W(SLOT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .slot  (slot)
  );

  dt_stamper #(.DATA_W(DATA_W), .SLOT_W(SLOT_W), .T_BOUND(T_BOUND)) u_stamp (
    .src_valid (src_valid),
    .src_ready (src_ready),
    .src_data  (src_data),
    .slot      (slot),
    .fab_valid (fab_valid),
    .fab_ready (fab_ready),
    .fab_data  (fab_data),
    .fab_due   (fab_due)
  );

  dt_hold_buffer #(.DATA_W(DATA_W), .SLOT_W(SLOT_W), .DEPTH(DEPTH)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot      (slot),
    .rcv_valid (rcv_valid),
    .rcv_data  (rcv_data),
    .rcv_due   (rcv_due),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .overflow  (overflow)
  );

  assign slot_now = slot;

endmodule

// File: tb/tb_dt_reseq.sv
`timescale 1ns/1ps
module tb_dt_reseq;

  localparam int DW   = 16;
  localparam int TB   = 5;
  localparam int SW   = 4;   // smallest width with 2^SW > 2*TB
  localparam int SC   = 4;
  localparam int DEP  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          src_valid = 1'b0, src_ready;
  logic [DW-1:0] src_data = '0;
  logic          fab_valid, fab_ready = 1'b0;
  logic [DW-1:0] fab_data;
  logic [SW-1:0] fab_due;
  logic          rcv_valid = 1'b0;
  logic [DW-1:0] rcv_data = '0;
  logic [SW-1:0] rcv_due = '0;
  logic          out_valid, out_ready = 1'b0;
  logic [DW-1:0] out_data;
  logic [SW-1:0] slot_now;
  logic          overflow;

  int checks = 0;
  int fails  = 0;
  int cyc_cnt = 0;
  int wd = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  dt_reseq #(.DATA_W(DW), .DEPTH(DEP), .SLOT_CYC(SC), .T_BOUND(TB)) dut (
    .clk(clk), .rst_n(rst_n),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
    .fab_valid(fab_valid), .fab_ready(fab_ready), .fab_data(fab_data), .fab_due(fab_due),
    .rcv_valid(rcv_valid), .rcv_data(rcv_data), .rcv_due(rcv_due),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .slot_now(slot_now), .overflow(overflow)
  );

  // Bench's own cycle count since reset release.
  always @(posedge clk) begin
    if (!rst_n) cyc_cnt <= 0;
    else        cyc_cnt <= cyc_cnt + 1;
  end

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 20000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog req=all actual=%0d expected=<20000 cycles", wd);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_cell(input logic [DW-1:0] d, input logic [SW-1:0] due);
    rcv_valid = 1'b1; rcv_data = d; rcv_due = due;
    @(negedge clk);
    rcv_valid = 1'b0;
  endtask

  task automatic pop_expect(input logic [DW-1:0] d, input string req);
    chk(out_valid === 1'b1, req, int'(out_valid), 1);
    chk(out_data === d, req, int'(out_data), int'(d));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic wait_slot(input logic [SW-1:0] s);
    while (slot_now !== s) @(negedge clk);
  endtask

  // Stamping vectors: {src_valid, fab_ready, src_data}
  localparam logic [17:0] STIM [6] = '{
    {1'b1, 1'b1, 16'hA001}, {1'b1, 1'b0, 16'hA002}, {1'b0, 1'b1, 16'h0000},
    {1'b1, 1'b1, 16'hBEEF}, {1'b0, 1'b0, 16'h1234}, {1'b1, 1'b1, 16'hFFFF}
  };

  initial begin
    logic [SW-1:0] s;
    logic [SW-1:0] d;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: reset state
    chk(out_valid === 1'b0, "R8 out_valid", int'(out_valid), 0);
    chk(overflow === 1'b0, "R8 overflow", int'(overflow), 0);
    chk(slot_now === '0, "R8 slot_now", int'(slot_now), 0);

    // R9: default bound arithmetic
    chk(dt_reseq_pkg::dt_bound(1024, 16, 5, 4) == 156, "R9 bound 1024",
        dt_reseq_pkg::dt_bound(1024, 16, 5, 4), 156);
    chk(dt_reseq_pkg::dt_bound(8192, 16, 5, 4) == 8200, "R9 bound 8192",
        dt_reseq_pkg::dt_bound(8192, 16, 5, 4), 8200);

    // R1: stamping vectors walked from the table
    for (int v = 0; v < 6; v++) begin
      src_valid = STIM[v][17];
      fab_ready = STIM[v][16];
      src_data  = STIM[v][15:0];
      #1;
      chk(fab_valid === STIM[v][17], "R1 fab_valid", int'(fab_valid), int'(STIM[v][17]));
      chk(src_ready === STIM[v][16], "R1 src_ready", int'(src_ready), int'(STIM[v][16]));
      chk(fab_data === STIM[v][15:0], "R1 fab_data", int'(fab_data), int'(STIM[v][15:0]));
      chk(fab_due === SW'(slot_now + SW'(TB)), "R1 fab_due", int'(fab_due),
          int'(SW'(slot_now + SW'(TB))));
      @(negedge clk);
      @(negedge clk);
    end
    src_valid = 1'b0; fab_ready = 1'b0;

    // R2: slot counter rate and wrap over more than one full period
    for (int k = 0; k < 80; k++) begin
      chk(slot_now === SW'((cyc_cnt / SC) % (1 << SW)), "R2 slot_now",
          int'(slot_now), (cyc_cnt / SC) % (1 << SW));
      @(negedge clk);
    end

    // R1 after wrap: stamp still modulo 2^k
    fab_ready = 1'b1; src_valid = 1'b1; #1;
    chk(fab_due === SW'(slot_now + SW'(TB)), "R1 fab_due wrap", int'(fab_due),
        int'(SW'(slot_now + SW'(TB))));
    @(negedge clk);
    src_valid = 1'b0; fab_ready = 1'b0;

    // R3: not before its slot, offered when it arrives
    s = slot_now; d = s + SW'(3);
    push_cell(16'h0303, d);
    for (int k = 0; k < 40 && slot_now !== d; k++) begin
      chk(out_valid === 1'b0, "R3 early", int'(out_valid), 0);
      @(negedge clk);
    end
    pop_expect(16'h0303, "R3 on due");
    chk(out_valid === 1'b0, "R3 drained", int'(out_valid), 0);

    // R4: arrival stamped with the current slot
    d = slot_now;
    push_cell(16'h0404, d);
    pop_expect(16'h0404, "R4 immediate");
    chk(out_valid === 1'b0, "R4 drained", int'(out_valid), 0);

    // R5: equal stamps leave in arrival order; a later stamp waits
    s = slot_now; d = s + SW'(2);
    push_cell(16'h0A0A, d);
    push_cell(16'h0B0B, d);
    push_cell(16'h0C0C, d);
    push_cell(16'h0D0D, d + SW'(1));
    wait_slot(d);
    pop_expect(16'h0A0A, "R5 first");
    pop_expect(16'h0B0B, "R5 second");
    pop_expect(16'h0C0C, "R5 third");
    if (slot_now === d)
      chk(out_valid === 1'b0, "R5 later stamp held", int'(out_valid), 0);
    wait_slot(d + SW'(1));
    pop_expect(16'h0D0D, "R5 later stamp");

    // R6: back-pressure across slots, lapsed older cell goes first
    s = slot_now;
    push_cell(16'h0606, s + SW'(1));
    push_cell(16'h0707, s + SW'(2));
    wait_slot(s + SW'(3));
    repeat (2) @(negedge clk);
    pop_expect(16'h0606, "R6 held older");
    pop_expect(16'h0707, "R6 held younger");
    chk(out_valid === 1'b0, "R6 drained", int'(out_valid), 0);

    // R7: full store drops the arrival and flags overflow
    s = slot_now; d = s + SW'(6);
    push_cell(16'h7001, d);
    push_cell(16'h7002, d);
    push_cell(16'h7003, d);
    push_cell(16'h7004, d);
    chk(overflow === 1'b0, "R7 no overflow at full", int'(overflow), 0);
    push_cell(16'h7005, d);
    chk(overflow === 1'b1, "R7 overflow set", int'(overflow), 1);
    wait_slot(d);
    pop_expect(16'h7001, "R7 kept 1");
    pop_expect(16'h7002, "R7 kept 2");
    pop_expect(16'h7003, "R7 kept 3");
    pop_expect(16'h7004, "R7 kept 4");
    chk(out_valid === 1'b0, "R7 dropped cell absent", int'(out_valid), 0);
    repeat (3) @(negedge clk);
    chk(overflow === 1'b1, "R7 overflow sticky", int'(overflow), 1);

    // R8: reset clears the sticky flag and the counter
    push_cell(16'h0808, slot_now + SW'(1));
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk(overflow === 1'b0, "R8 overflow cleared", int'(overflow), 0);
    chk(slot_now === '0, "R8 slot cleared", int'(slot_now), 0);
    for (int k = 0; k < 12; k++) begin
      chk(out_valid === 1'b0, "R8 store emptied", int'(out_valid), 0);
      @(negedge clk);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule